// File: doc/BRIEF.md
# Privileged Context Register Access Checker

This block is a small slice of a processor's system-register space. It holds four 64-bit software context-number registers, one for each privilege level from 0 to 3. It accepts one register access per cycle. Each access carries a five-field encoding (op0, op1, CRn, CRm, op2), a read/write flag and the current privilege level. The block decodes the encoding and redirects alias encodings when host-hypervisor mode is active. It checks privilege, then evaluates the trap conditions in a fixed order of priority. The answer is read data, a register write, or a trap together with the level that should handle it.

The trap conditions come from a trap bit in each of the level-1 and level-2 control registers and from two enable bits. One enable bit sits in the hypervisor configuration and one in the secure configuration. Those two enable bits are held inside the block. Each has its own write strobe. A parameter states whether the context feature exists; without it, both enable bits read as zero and cannot be set. The response is combinational in the cycle of the request. An accepted write updates the register at the next rising clock edge.

Top module: `ctx_access_unit`

## Requirements
- R1: An encoding is decoded only when op0=3, CRn=13, CRm=0 and op2=7. Within that space, op1=3 selects the level-0 register, op1=0 the level-1 register, op1=4 the level-2 register and op1=6 the level-3 register. A read that does not trap returns the selected register.
- R2: At level 2 with host-hypervisor mode set, op1=0 selects the level-2 register and op1=5 selects the level-1 register. Outside that case, op1=0 selects the level-1 register and op1=5 is undecoded.
- R3: An undecoded encoding traps to level 1 (trap level code 1). So does a register whose own level is above the current level, or a level-3 register reached from below level 3. This check takes priority over every control-bit trap.
- R4: At level 0, unless host mode and trap-general are both set, a set level-1 trap bit traps the access. The target is level 2 when trap-general is 1 and level 1 when it is 0.
- R5: In every other case, an access from level 0 or 1 traps to level 2 when the level-2 trap bit is set. A level-0 access outside host mode never consults the level-2 trap bit. A level-2 access never traps on either trap bit.
- R6: After R4 and R5, an access from level 0 or 1 traps to level 2 when level 2 is enabled and the hypervisor enable bit is clear.
- R7: Last, an access from below level 3 traps to level 3 when level 3 is implemented and the secure enable bit is clear.
- R8: An access to the level-3 register at level 3 never traps, whatever the control bits hold.
- R9: A trapped access leaves every register unchanged and returns read data of zero.
- R10: With the feature present, each enable bit takes its input value on the edge after its write strobe. Without the feature, both enable bits stay zero.
- R11: Reset clears all four registers and both enable bits. An accepted write is visible on the edge after the request, not during the request cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Access request present |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_el_i | input | 2 | Current privilege level |
| req_op0_i | input | 2 | Encoding field op0 |
| req_op1_i | input | 3 | Encoding field op1 |
| req_crn_i | input | 4 | Encoding field CRn |
| req_crm_i | input | 4 | Encoding field CRm |
| req_op2_i | input | 3 | Encoding field op2 |
| req_wdata_i | input | 64 | Write data |
| host_mode_i | input | 1 | Host-hypervisor mode active |
| trap_gen_i | input | 1 | Trap-general routing bit |
| l1_trap_bit_i | input | 1 | Trap bit in the level-1 control register |
| l2_trap_bit_i | input | 1 | Trap bit in the level-2 control register |
| l2_enabled_i | input | 1 | Level 2 enabled |
| l3_present_i | input | 1 | Level 3 implemented |
| hyp_en_we_i | input | 1 | Write strobe for the hypervisor enable bit |
| hyp_en_i | input | 1 | New hypervisor enable value |
| sec_en_we_i | input | 1 | Write strobe for the secure enable bit |
| sec_en_i | input | 1 | New secure enable value |
| rdata_o | output | 64 | Read data (zero on writes and traps) |
| trap_valid_o | output | 1 | Access traps |
| trap_el_o | output | 2 | Level that takes the trap |
| hyp_en_o | output | 1 | Current hypervisor enable bit |
| sec_en_o | output | 1 | Current secure enable bit |

## Verification
The hardest corner to reach is the one where the trap order itself decides the result. One case is a level-0 access outside host mode with the level-1 trap bit clear but the level-2 trap bit set, which must succeed. Another is an undecoded access made while every control bit would also trap. The directed tasks first seed the registers with distinct values from level 3, where nothing traps. They then move one control input at a time between accesses and compare the trap level and read data with a value fixed by hand. Trapped writes are checked by reading the register back from level 3.

// File: rtl/ctx_pkg.sv
package ctx_pkg;
  localparam int unsigned NUM_LVL = 4;
  localparam int unsigned LVL_W   = 2;

  localparam logic [1:0] ENC_OP0 = 2'd3;
  localparam logic [3:0] ENC_CRN = 4'd13;
  localparam logic [3:0] ENC_CRM = 4'd0;
  localparam logic [2:0] ENC_OP2 = 3'd7;

  localparam logic [2:0] OP1_L0    = 3'd3;
  localparam logic [2:0] OP1_L1    = 3'd0;
  localparam logic [2:0] OP1_L2    = 3'd4;
  localparam logic [2:0] OP1_L3    = 3'd6;
  localparam logic [2:0] OP1_ALIAS = 3'd5;

  typedef struct packed {
    logic             hit;
    logic [LVL_W-1:0] tgt;
  } dec_t;
endpackage

// File: rtl/ctx_decode.sv
module ctx_decode
  import ctx_pkg::*;
(
  input  logic [1:0]       op0_i,
  input  logic [2:0]       op1_i,
  input  logic [3:0]       crn_i,
  input  logic [3:0]       crm_i,
  input  logic [2:0]       op2_i,
  input  logic [LVL_W-1:0] el_i,
  input  logic             host_mode_i,
  output dec_t             dec_o,
  output logic             undef_o
);
  logic space_hit;
  logic redirect;
  logic priv_ok;

  assign space_hit = (op0_i == ENC_OP0) && (crn_i == ENC_CRN) &&
                     (crm_i == ENC_CRM) && (op2_i == ENC_OP2);
  assign redirect  = host_mode_i && (el_i == 2'd2);

  always_comb begin
    dec_o = '0;
    if (space_hit) begin
      unique case (op1_i)
        OP1_L0:    dec_o = '{hit: 1'b1, tgt: 2'd0};
        OP1_L1:    dec_o = '{hit: 1'b1, tgt: redirect ? 2'd2 : 2'd1};
        OP1_L2:    dec_o = '{hit: 1'b1, tgt: 2'd2};
        OP1_L3:    dec_o = '{hit: 1'b1, tgt: 2'd3};
        OP1_ALIAS: dec_o = '{hit: redirect, tgt: 2'd1};
        default:   dec_o = '0;
      endcase
    end
  end

  // level-3 register only from level 3; others need el >= own level
  assign priv_ok = (dec_o.tgt == 2'd3) ? (el_i == 2'd3) : (el_i >= dec_o.tgt);
  assign undef_o = !dec_o.hit || !priv_ok;
endmodule

// File: rtl/ctx_trap.sv
module ctx_trap
  import ctx_pkg::*;
(
  input  logic [LVL_W-1:0] el_i,
  input  logic             undef_i,
  input  logic             tgt_top_i,
  input  logic             host_mode_i,
  input  logic             trap_gen_i,
  input  logic             l1_trap_bit_i,
  input  logic             l2_trap_bit_i,
  input  logic             l2_enabled_i,
  input  logic             l3_present_i,
  input  logic             hyp_en_i,
  input  logic             sec_en_i,
  output logic             trap_o,
  output logic [LVL_W-1:0] trap_el_o
);
  logic below2, below3;
  assign below2 = (el_i < 2'd2);
  assign below3 = (el_i != 2'd3);

  always_comb begin
    trap_o    = 1'b0;
    trap_el_o = '0;
    if (undef_i) begin
      trap_o    = 1'b1;
      trap_el_o = 2'd1;
    end else if (!tgt_top_i) begin
      if ((el_i == 2'd0) && !(host_mode_i && trap_gen_i)) begin
        if (l1_trap_bit_i) begin
          trap_o    = 1'b1;
          trap_el_o = trap_gen_i ? 2'd2 : 2'd1;
        end
      end else if (below2 && l2_trap_bit_i) begin
        trap_o    = 1'b1;
        trap_el_o = 2'd2;
      end
      if (!trap_o && below2 && l2_enabled_i && !hyp_en_i) begin
        trap_o    = 1'b1;
        trap_el_o = 2'd2;
      end
      if (!trap_o && below3 && l3_present_i && !sec_en_i) begin
        trap_o    = 1'b1;
        trap_el_o = 2'd3;
      end
    end
  end
endmodule

// File: rtl/ctx_regs.sv
module ctx_regs #(
  parameter int unsigned NUM    = 4,
  parameter int unsigned DATA_W = 64,
  localparam int unsigned SEL_W = $clog2(NUM)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       we_i,
  input  logic [SEL_W-1:0]           sel_i,
  input  logic [DATA_W-1:0]          wdata_i,
  output logic [NUM-1:0][DATA_W-1:0] q_o
);
  for (genvar g = 0; g < NUM; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                q_o[g] <= '0;
      else if (we_i && (sel_i == SEL_W'(g)))      q_o[g] <= wdata_i;
    end
  end
endmodule

// File: rtl/ctx_access_unit.sv
module ctx_access_unit
  import ctx_pkg::*;
#(
  parameter int unsigned DATA_W   = 64,
  parameter bit          HAS_FEAT = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [1:0]        req_el_i,
  input  logic [1:0]        req_op0_i,
  input  logic [2:0]        req_op1_i,
  input  logic [3:0]        req_crn_i,
  input  logic [3:0]        req_crm_i,
  input  logic [2:0]        req_op2_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic              host_mode_i,
  input  logic              trap_gen_i,
  input  logic              l1_trap_bit_i,
  input  logic              l2_trap_bit_i,
  input  logic              l2_enabled_i,
  input  logic              l3_present_i,
  input  logic              hyp_en_we_i,
  input  logic              hyp_en_i,
  input  logic              sec_en_we_i,
  input  logic              sec_en_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              trap_valid_o,
  output logic [1:0]        trap_el_o,
  output logic              hyp_en_o,
  output logic              sec_en_o
);
  dec_t dec;
  logic undef, trap, wr_acc;
  logic [LVL_W-1:0] trap_el;
  logic [NUM_LVL-1:0][DATA_W-1:0] regs_q;

  ctx_decode u_dec (
    .op0_i(req_op0_i), .op1_i(req_op1_i), .crn_i(req_crn_i), .crm_i(req_crm_i),
    .op2_i(req_op2_i), .el_i(req_el_i), .host_mode_i(host_mode_i),
    .dec_o(dec), .undef_o(undef)
  );

  ctx_trap u_trap (
    .el_i(req_el_i), .undef_i(undef), .tgt_top_i(dec.tgt == 2'd3),
    .host_mode_i(host_mode_i), .trap_gen_i(trap_gen_i),
    .l1_trap_bit_i(l1_trap_bit_i), .l2_trap_bit_i(l2_trap_bit_i),
    .l2_enabled_i(l2_enabled_i), .l3_present_i(l3_present_i),
    .hyp_en_i(hyp_en_o), .sec_en_i(sec_en_o),
    .trap_o(trap), .trap_el_o(trap_el)
  );

  assign wr_acc = req_valid_i && req_write_i && !trap;

  ctx_regs #(.NUM(NUM_LVL), .DATA_W(DATA_W)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(wr_acc), .sel_i(dec.tgt),
    .wdata_i(req_wdata_i), .q_o(regs_q)
  );

  assign trap_valid_o = req_valid_i && trap;
  assign trap_el_o    = trap_valid_o ? trap_el : '0;
  assign rdata_o      = (req_valid_i && !req_write_i && !trap) ? regs_q[dec.tgt] : '0;

  if (HAS_FEAT) begin : g_en
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        hyp_en_o <= 1'b0;
        sec_en_o <= 1'b0;
      end else begin
        if (hyp_en_we_i) hyp_en_o <= hyp_en_i;
        if (sec_en_we_i) sec_en_o <= sec_en_i;
      end
    end
  end else begin : g_no_en
    assign hyp_en_o = 1'b0;
    assign sec_en_o = 1'b0;
  end

  // R3
  undef_prio_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && undef) |-> (trap_valid_o && trap_el_o == 2'd1));
  // R9
  trap_rdata_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_valid_o |-> (rdata_o == '0));
  // R9
  trap_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_valid_o |=> $stable(regs_q));
  // R8
  top_reg_free_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && dec.hit && dec.tgt == 2'd3 && req_el_i == 2'd3) |-> !trap_valid_o);
  // R7
  sec_route_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_valid_o && trap_el_o == 2'd3) |-> (!sec_en_o && l3_present_i));
  // R11
  write_land_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_acc |=> (regs_q[$past(dec.tgt)] == $past(req_wdata_i)));
  // R10
  no_feat_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !HAS_FEAT |-> (!hyp_en_o && !sec_en_o));
endmodule

// File: tb/tb_ctx_access_unit.sv
module tb_ctx_access_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        vld = 0, wr = 0;
  logic [1:0]  el = 0, op0 = 3;
  logic [2:0]  op1 = 0, op2 = 7;
  logic [3:0]  crn = 13, crm = 0;
  logic [63:0] wd = 0;
  logic hm = 0, tg = 0, t1 = 0, t2 = 0, l2e = 1, l3p = 1;
  logic hwe = 0, hin = 0, swe = 0, sin = 0;
  logic [63:0] rd, rd_nf;
  logic tv, tv_nf, hen, sen, hen_nf, sen_nf;
  logic [1:0] te, te_nf;

  int checks = 0, errors = 0;
  logic [63:0] got_rd;
  logic [2:0]  got_tr;

  ctx_access_unit dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(vld), .req_write_i(wr), .req_el_i(el),
    .req_op0_i(op0), .req_op1_i(op1), .req_crn_i(crn), .req_crm_i(crm), .req_op2_i(op2),
    .req_wdata_i(wd), .host_mode_i(hm), .trap_gen_i(tg), .l1_trap_bit_i(t1),
    .l2_trap_bit_i(t2), .l2_enabled_i(l2e), .l3_present_i(l3p),
    .hyp_en_we_i(hwe), .hyp_en_i(hin), .sec_en_we_i(swe), .sec_en_i(sin),
    .rdata_o(rd), .trap_valid_o(tv), .trap_el_o(te), .hyp_en_o(hen), .sec_en_o(sen));

  ctx_access_unit #(.HAS_FEAT(1'b0)) dut_nf (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(vld), .req_write_i(wr), .req_el_i(el),
    .req_op0_i(op0), .req_op1_i(op1), .req_crn_i(crn), .req_crm_i(crm), .req_op2_i(op2),
    .req_wdata_i(wd), .host_mode_i(hm), .trap_gen_i(tg), .l1_trap_bit_i(t1),
    .l2_trap_bit_i(t2), .l2_enabled_i(l2e), .l3_present_i(l3p),
    .hyp_en_we_i(hwe), .hyp_en_i(hin), .sec_en_we_i(swe), .sec_en_i(sin),
    .rdata_o(rd_nf), .trap_valid_o(tv_nf), .trap_el_o(te_nf), .hyp_en_o(hen_nf),
    .sec_en_o(sen_nf));

  task automatic check(string req, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // one access; captures {trap_valid, trap_el} and rdata mid-cycle
  task automatic acc(logic w, logic [1:0] l, logic [2:0] o1, logic [63:0] d);
    @(negedge clk);
    vld = 1; wr = w; el = l; op1 = o1; wd = d;
    #1;
    got_rd = rd;
    got_tr = {tv, te};
    @(posedge clk);
    #1;
    vld = 0; wr = 0;
  endtask

  task automatic set_en(logic h, logic s);
    @(negedge clk);
    hwe = 1; hin = h; swe = 1; sin = s;
    @(negedge clk);
    hwe = 0; swe = 0;
  endtask

  task automatic ctl(logic h, logic g, logic a, logic b, logic e2, logic e3);
    hm = h; tg = g; t1 = a; t2 = b; l2e = e2; l3p = e3;
  endtask

  localparam logic [63:0] V0 = 64'h0000_0000_0000_00a0;
  localparam logic [63:0] V1 = 64'h1111_2222_3333_4444;
  localparam logic [63:0] V2 = 64'hdead_beef_0000_0002;
  localparam logic [63:0] V3 = 64'hffff_0000_ffff_0003;

  task automatic t_reset;
    check("R11 reset hyp_en", {63'd0, hen}, 64'd0);
    check("R11 reset sec_en", {63'd0, sen}, 64'd0);
    ctl(0, 0, 0, 0, 0, 0);
    acc(0, 3, 3'd3, 0); check("R11 reset reg0", got_rd, 0);
    acc(0, 3, 3'd0, 0); check("R11 reset reg1", got_rd, 0);
    acc(0, 3, 3'd4, 0); check("R11 reset reg2", got_rd, 0);
    acc(0, 3, 3'd6, 0); check("R11 reset reg3", got_rd, 0);
  endtask

  task automatic t_decode;
    ctl(0, 0, 0, 0, 1, 1);
    set_en(1, 1);
    check("R10 hyp_en set", {63'd0, hen}, 64'd1);
    check("R10 sec_en set", {63'd0, sen}, 64'd1);
    acc(1, 3, 3'd3, V0);
    check("R11 no read data on write", got_rd, 0);
    acc(1, 3, 3'd0, V1); acc(1, 3, 3'd4, V2); acc(1, 3, 3'd6, V3);
    acc(0, 3, 3'd3, 0); check("R1 op1=3 level0", got_rd, V0);
    acc(0, 3, 3'd0, 0); check("R1 op1=0 level1", got_rd, V1);
    acc(0, 3, 3'd4, 0); check("R1 op1=4 level2", got_rd, V2);
    acc(0, 3, 3'd6, 0); check("R1 op1=6 level3", got_rd, V3);
    acc(0, 0, 3'd3, 0); check("R1 level0 reads own", got_rd, V0);
    check("R1 level0 no trap", {61'd0, got_tr}, 0);
  endtask

  task automatic t_alias;
    ctl(1, 0, 0, 0, 1, 1);
    acc(0, 2, 3'd0, 0); check("R2 redirect op1=0 to level2", got_rd, V2);
    acc(0, 2, 3'd5, 0); check("R2 alias op1=5 to level1", got_rd, V1);
    ctl(0, 0, 0, 0, 1, 1);
    acc(0, 2, 3'd0, 0); check("R2 no redirect without host", got_rd, V1);
    acc(0, 2, 3'd5, 0); check("R2 alias undecoded without host", {61'd0, got_tr}, 3'b101);
    ctl(1, 0, 0, 0, 1, 1);
    acc(0, 1, 3'd5, 0); check("R2 alias undecoded at level1", {61'd0, got_tr}, 3'b101);
  endtask

  task automatic t_undef;
    ctl(0, 0, 1, 1, 1, 1);
    set_en(0, 0);
    acc(0, 0, 3'd0, 0); check("R3 level0 to reg1 undef", {61'd0, got_tr}, 3'b101);
    acc(0, 1, 3'd4, 0); check("R3 level1 to reg2 undef", {61'd0, got_tr}, 3'b101);
    acc(0, 2, 3'd6, 0); check("R3 level2 to reg3 undef", {61'd0, got_tr}, 3'b101);
    @(negedge clk); crm = 4'd1;
    acc(0, 3, 3'd6, 0); check("R3 bad CRm undef", {61'd0, got_tr}, 3'b101);
    @(negedge clk); crm = 4'd0; op2 = 3'd6;
    acc(0, 3, 3'd6, 0); check("R3 bad op2 undef", {61'd0, got_tr}, 3'b101);
    @(negedge clk); op2 = 3'd7;
    acc(0, 3, 3'd7, 0); check("R3 op1=7 undef", {61'd0, got_tr}, 3'b101);
    set_en(1, 1);
  endtask

  task automatic t_l1bit;
    ctl(0, 0, 1, 0, 1, 1);
    acc(0, 0, 3'd3, 0); check("R4 tge0 to level1", {61'd0, got_tr}, 3'b101);
    check("R9 rdata zero on trap", got_rd, 0);
    ctl(0, 1, 1, 0, 1, 1);
    acc(0, 0, 3'd3, 0); check("R4 tge1 to level2", {61'd0, got_tr}, 3'b110);
    ctl(1, 0, 1, 0, 1, 1);
    acc(0, 0, 3'd3, 0); check("R4 host only tge0 to level1", {61'd0, got_tr}, 3'b101);
    ctl(1, 1, 1, 0, 1, 1);
    acc(0, 0, 3'd3, 0); check("R4 host+tge ignores level1 bit", got_rd, V0);
    ctl(0, 0, 0, 0, 1, 1);
    acc(0, 1, 3'd0, 0);
    ctl(0, 0, 1, 0, 1, 1);
    acc(0, 1, 3'd0, 0); check("R4 level1 ignores level1 bit", got_rd, V1);
  endtask

  task automatic t_l2bit;
    ctl(0, 0, 0, 1, 1, 1);
    acc(0, 1, 3'd0, 0); check("R5 level1 to level2", {61'd0, got_tr}, 3'b110);
    ctl(1, 1, 0, 1, 1, 1);
    acc(0, 0, 3'd3, 0); check("R5 host level0 to level2", {61'd0, got_tr}, 3'b110);
    ctl(0, 0, 0, 1, 1, 1);
    acc(0, 0, 3'd3, 0); check("R5 level0 non-host skips level2 bit", got_rd, V0);
    acc(0, 2, 3'd4, 0); check("R5 level2 unaffected", got_rd, V2);
  endtask

  task automatic t_hyp;
    ctl(0, 0, 0, 0, 1, 1);
    set_en(0, 1);
    acc(0, 1, 3'd0, 0); check("R6 hyp enable clear to level2", {61'd0, got_tr}, 3'b110);
    acc(0, 0, 3'd3, 0); check("R6 level0 hyp enable clear", {61'd0, got_tr}, 3'b110);
    ctl(0, 0, 0, 0, 0, 1);
    acc(0, 1, 3'd0, 0); check("R6 level2 disabled no trap", got_rd, V1);
    ctl(0, 0, 0, 0, 1, 1);
    acc(0, 2, 3'd4, 0); check("R6 level2 access no trap", got_rd, V2);
    set_en(0, 0);
    ctl(0, 1, 1, 0, 1, 1);
    acc(0, 0, 3'd3, 0); check("R4 priority over R6/R7", {61'd0, got_tr}, 3'b110);
    ctl(0, 0, 0, 0, 1, 1);
    acc(0, 1, 3'd0, 0); check("R6 priority over R7", {61'd0, got_tr}, 3'b110);
  endtask

  task automatic t_sec;
    set_en(1, 0);
    ctl(0, 0, 0, 0, 1, 1);
    acc(0, 2, 3'd4, 0); check("R7 level2 to level3", {61'd0, got_tr}, 3'b111);
    acc(0, 1, 3'd0, 0); check("R7 level1 to level3", {61'd0, got_tr}, 3'b111);
    acc(0, 3, 3'd4, 0); check("R7 level3 not trapped", got_rd, V2);
    ctl(0, 0, 0, 0, 1, 0);
    acc(0, 2, 3'd4, 0); check("R7 no level3 no trap", got_rd, V2);
  endtask

  task automatic t_top;
    set_en(0, 0);
    ctl(0, 1, 1, 1, 1, 1);
    acc(0, 3, 3'd6, 0); check("R8 level3 reg free", got_rd, V3);
    check("R8 level3 no trap", {61'd0, got_tr}, 0);
    acc(1, 3, 3'd6, 64'h5a5a); acc(0, 3, 3'd6, 0);
    check("R8 level3 write lands", got_rd, 64'h5a5a);
  endtask

  task automatic t_trapwrite;
    set_en(0, 1);
    ctl(0, 0, 0, 0, 1, 1);
    acc(1, 1, 3'd0, 64'h77); check("R9 write trapped", {61'd0, got_tr}, 3'b110);
    acc(1, 0, 3'd0, 64'h88); check("R9 undef write trapped", {61'd0, got_tr}, 3'b101);
    acc(0, 3, 3'd0, 0); check("R9 reg1 unchanged", got_rd, V1);
    acc(0, 3, 3'd3, 0); check("R9 reg0 unchanged", got_rd, V0);
    set_en(1, 1);
    @(negedge clk);
    vld = 1; wr = 1; el = 1; op1 = 3'd0; wd = 64'h99;
    @(posedge clk); #1;
    wr = 0;
    #1;
    check("R11 write visible after edge", rd, 64'h99);
    @(negedge clk); vld = 0;
  endtask

  task automatic t_feat;
    set_en(1, 1);
    check("R10 no feature hyp stays 0", {63'd0, hen_nf}, 0);
    check("R10 no feature sec stays 0", {63'd0, sen_nf}, 0);
    check("R10 feature hyp", {63'd0, hen}, 1);
    set_en(0, 1);
    check("R10 feature hyp cleared", {63'd0, hen}, 0);
    check("R10 feature sec kept", {63'd0, sen}, 1);
  endtask

  bit done = 0;
  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset; t_decode; t_alias; t_undef; t_l1bit; t_l2bit;
    t_hyp; t_sec; t_top; t_trapwrite; t_feat;
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule